// File: doc/BRIEF.md
# Single-Cell Charge Sequencer

This block is the digital state machine that steps a single lithium cell through a charge cycle. It receives digitized comparator results from the analog front end and a 1 kHz timebase pulse. Its outputs are a phase code for the current and voltage regulation loops, two derating enables for the warm temperature band, and an active-low status request that drives an open-drain indicator. The regulation loops and the comparators are outside this block.

Charging begins only after a validated input is reported. A deeply discharged cell receives a reduced pre-conditioning current, and the block moves on to full-current charging once the cell crosses the upper threshold. When the float voltage is reached, the block holds voltage regulation until a qualified taper declares the cycle complete. A later sag below the recharge level starts a new cycle. Two conditions latch the block into a fault that only removal of input power clears: a cell that never leaves the short-circuit region, and a shorted current-setting resistor. Temperature-band conditions and die-temperature conditions pause or derate charging without losing the charge phase.

Top module: `chg_seq`

## Requirements
- R1: After reset, and whenever `in_ok` is low, `mode` is OFF (000) and `stat_n` is 1. Mode codes: OFF 000, PRE 001, FAST 010, FLOAT 011, DONE 100, FAULT 101.
- R2: Once `in_ok` is high, with no resistor short flagged, the block leaves OFF on the next clock. It enters PRE when `above_fast` is 0 and FAST when it is 1. From PRE it moves to FAST on the clock where `above_fast` is 1. `stat_n` is 0 in both phases.
- R3: In PRE, each `tick` that arrives while `above_short` is 0 advances a dwell count. When the count reaches PRE_MS (32), the block enters FAULT. The count restarts whenever `above_short` goes high.
- R4: In OFF with `in_ok` high and `rset_short` high, the block waits for the flag to persist over RSET_MS (1) ticks and then enters FAULT.
- R5: FAULT ignores every input except `in_ok`, and `stat_n` is 1 throughout. A low `in_ok` returns the block to OFF.
- R6: In FAST, `at_float` high moves the block to FLOAT. In FLOAT, `at_float` low returns it to FAST.
- R7: FLOAT becomes DONE only after END_MS (32) ticks during which `at_float` and `below_end` both stay high. Any drop restarts the count. In DONE, `stat_n` is 1.
- R8: In DONE, `below_rch` high starts a new cycle in FAST (or in PRE when `above_fast` is 0), and `stat_n` returns to 0.
- R9: `ntc_zone` encoding: 00 normal, 01 warm, 10 cold, 11 hot. In the warm zone, a charging phase keeps its mode, `stat_n` is 0, and `float_derate` and `fast_derate` are 1. Outside the warm zone, both derating enables are 0.
- R10: In the cold or hot zone, a charging phase (PRE, FAST or FLOAT) shows mode OFF with `stat_n` 1. The phase resumes when the zone returns to normal or warm.
- R11: `die_hot` suspends charging in the same way as R10. The suspension lasts until `die_reg` is low. `die_reg` on its own leaves charging and `stat_n` unchanged.
- R12: When `in_ok` drops in any state, the block is OFF on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle 1 kHz timebase pulse |
| in_ok | input | 1 | Input supply validated |
| above_short | input | 1 | Cell above short-circuit level |
| above_fast | input | 1 | Cell above pre-to-fast level |
| at_float | input | 1 | Loop regulating at float voltage |
| below_end | input | 1 | Charge current below end-of-charge level |
| below_rch | input | 1 | Cell below recharge level |
| rset_short | input | 1 | Current-setting resistor shorted |
| die_hot | input | 1 | Die above shutdown temperature |
| die_reg | input | 1 | Die above regulation temperature |
| ntc_zone | input | 2 | Cell temperature band |
| mode | output | 3 | Charge phase code |
| float_derate | output | 1 | Lower float target |
| fast_derate | output | 1 | Lower fast current |
| stat_n | output | 1 | Active-low status request |

## Verification
Every state maps to a distinct mode code, so a wrong transition appears on `mode` on the clock edge that follows the offending input. Off-by-one errors in the dwell counts show up only at the expiring tick. The bench therefore samples one tick before and one tick after each limit, and after each restart of a count. A suspension or derating that is decoded wrongly shows up immediately on `stat_n` and on the enables, because these are combinational from state and inputs.

// File: rtl/chg_seq.sv
module chg_seq #(
  parameter int PRE_MS  = 32,
  parameter int END_MS  = 32,
  parameter int RSET_MS = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       in_ok,
  input  logic       above_short,
  input  logic       above_fast,
  input  logic       at_float,
  input  logic       below_end,
  input  logic       below_rch,
  input  logic       rset_short,
  input  logic       die_hot,
  input  logic       die_reg,
  input  logic [1:0] ntc_zone,
  output logic [2:0] mode,
  output logic       float_derate,
  output logic       fast_derate,
  output logic       stat_n
);
  localparam logic [2:0] S_OFF = 3'd0, S_PRE = 3'd1, S_FAST = 3'd2,
                         S_FLT = 3'd3, S_DONE = 3'd4, S_FAULT = 3'd5;
  localparam int LIM_A = (PRE_MS > END_MS) ? PRE_MS : END_MS;
  localparam int LIM_MAX = (LIM_A > RSET_MS) ? LIM_A : RSET_MS;
  localparam int CW = $clog2(LIM_MAX + 1);

  logic [2:0] st, nx;
  logic [CW-1:0] cnt;
  logic tsd, qual, expire;
  int lim;

  wire warm   = ntc_zone == 2'b01;
  wire hold   = tsd | ntc_zone[1];
  wire active = (st == S_PRE) | (st == S_FAST) | (st == S_FLT);
  wire run    = active & ~hold;

  always_comb begin
    qual = 1'b0;
    lim  = LIM_MAX;
    case (st)
      S_OFF: begin qual = in_ok & rset_short;        lim = RSET_MS; end
      S_PRE: begin qual = ~above_short & ~hold;      lim = PRE_MS;  end
      S_FLT: begin qual = at_float & below_end & ~hold; lim = END_MS; end
      default: ;
    endcase
  end

  assign expire = qual & tick & (int'(cnt) == lim - 1);

  always_comb begin
    nx = st;
    if (!in_ok) nx = S_OFF;
    else begin
      case (st)
        S_OFF:  if (rset_short) nx = expire ? S_FAULT : S_OFF;
                else nx = above_fast ? S_FAST : S_PRE;
        S_PRE:  if (expire) nx = S_FAULT;
                else if (above_fast) nx = S_FAST;
        S_FAST: if (at_float) nx = S_FLT;
        S_FLT:  if (expire) nx = S_DONE;
                else if (!at_float) nx = S_FAST;
        S_DONE: if (below_rch) nx = above_fast ? S_FAST : S_PRE;
        default: nx = S_FAULT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_OFF;
      cnt <= '0;
      tsd <= 1'b0;
    end else begin
      st <= nx;
      if (nx != st || !qual) cnt <= '0;
      else if (tick) cnt <= cnt + 1'b1;
      if (die_hot) tsd <= 1'b1;
      else if (!die_reg) tsd <= 1'b0;
    end
  end

  assign mode         = (active & hold) ? S_OFF : st;
  assign stat_n       = ~run;
  assign fast_derate  = run & warm;
  assign float_derate = run & warm;

  p_fault_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FAULT && in_ok) |=> (mode == S_FAULT && stat_n));
  p_off_on_loss_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ok |=> (mode == S_OFF));
  p_done_released_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == S_DONE) |-> stat_n);
  p_done_from_float_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DONE && $past(st) != S_DONE) |-> $past(st) == S_FLT);
  p_warm_keeps_stat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fast_derate |-> (!stat_n && ntc_zone == 2'b01));
  p_validated_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != S_OFF && mode != S_FAULT) |-> $past(in_ok));
  p_cold_hot_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ntc_zone[1] |-> stat_n);
endmodule

// File: tb/test_chg_seq.sv
`timescale 1ns/1ps
module test_chg_seq;
  logic clk = 0, rst_n = 0, tick = 0, in_ok = 0, above_short = 0, above_fast = 0;
  logic at_float = 0, below_end = 0, below_rch = 0, rset_short = 0, die_hot = 0, die_reg = 0;
  logic [1:0] ntc_zone = 2'b00;
  logic [2:0] mode;
  logic float_derate, fast_derate, stat_n;
  int n_chk = 0, n_bad = 0;

  chg_seq i_chg_seq (.clk, .rst_n, .tick, .in_ok, .above_short, .above_fast, .at_float,
    .below_end, .below_rch, .rset_short, .die_hot, .die_reg, .ntc_zone, .mode,
    .float_derate, .fast_derate, .stat_n);

  always #2.5 clk = ~clk;

  task automatic chk(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin tick = 1; step(); tick = 0; end
  endtask

  task automatic restart();
    in_ok = 0; step(); in_ok = 1;
  endtask

  task automatic t_reset();
    chk("R1 reset mode", mode, 0); chk("R1 reset stat", stat_n, 1);
    rst_n = 1; step(); step();
    chk("R1 no input mode", mode, 0); chk("R1 no input stat", stat_n, 1);
  endtask

  task automatic t_phase();
    above_short = 1; above_fast = 0; in_ok = 1; step();
    chk("R2 pre mode", mode, 1); chk("R2 pre stat", stat_n, 0);
    above_fast = 1; step();
    chk("R2 fast mode", mode, 2); chk("R2 fast stat", stat_n, 0);
  endtask

  task automatic t_pre_fault();
    above_short = 0; above_fast = 0; restart(); step();
    chk("R3 in pre", mode, 1);
    ticks(20); above_short = 1; step(); above_short = 0;
    ticks(20); chk("R3 restart", mode, 1);
    ticks(11); chk("R3 one short", mode, 1);
    ticks(1); chk("R3 fault", mode, 5); chk("R3 fault stat", stat_n, 1);
    above_short = 1; above_fast = 1; at_float = 1; below_rch = 1; ticks(3);
    chk("R5 latched", mode, 5); chk("R5 latched stat", stat_n, 1);
    at_float = 0; below_rch = 0;
    in_ok = 0; step(); chk("R5 cleared", mode, 0);
    in_ok = 1; step(); chk("R5 resume", mode, 2);
  endtask

  task automatic t_rset();
    rset_short = 1; restart(); step();
    chk("R4 waiting", mode, 0); chk("R4 waiting stat", stat_n, 1);
    ticks(1); chk("R4 fault", mode, 5);
    rset_short = 0; step(); chk("R4 stays", mode, 5);
    restart(); step(); chk("R4 clean start", mode, 2);
  endtask

  task automatic t_eoc();
    at_float = 1; step(); chk("R6 float", mode, 3);
    below_end = 1; ticks(20); at_float = 0; step(); chk("R6 back fast", mode, 2);
    at_float = 1; step(); chk("R6 float again", mode, 3);
    ticks(31); chk("R7 not yet", mode, 3); chk("R7 stat", stat_n, 0);
    ticks(1); chk("R7 done", mode, 4); chk("R7 done stat", stat_n, 1);
    at_float = 0; below_end = 0; below_rch = 1; step();
    chk("R8 recharge", mode, 2); chk("R8 stat", stat_n, 0);
    below_rch = 0;
  endtask

  task automatic t_ntc();
    ntc_zone = 2'b01; #1;
    chk("R9 warm mode", mode, 2); chk("R9 warm stat", stat_n, 0);
    chk("R9 fast derate", fast_derate, 1); chk("R9 float derate", float_derate, 1);
    ntc_zone = 2'b10; step();
    chk("R10 cold mode", mode, 0); chk("R10 cold stat", stat_n, 1); chk("R9 no derate", fast_derate, 0);
    ntc_zone = 2'b11; step(); chk("R10 hot stat", stat_n, 1);
    ntc_zone = 2'b00; step(); chk("R10 resume", mode, 2); chk("R9 normal", float_derate, 0);
  endtask

  task automatic t_therm();
    die_reg = 1; step(); chk("R11 reg keeps", mode, 2); chk("R11 reg stat", stat_n, 0);
    die_hot = 1; step(); chk("R11 shutdown", mode, 0); chk("R11 shutdown stat", stat_n, 1);
    die_hot = 0; step(); chk("R11 still hot", stat_n, 1);
    die_reg = 0; step(); chk("R11 cooled", mode, 2); chk("R11 cooled stat", stat_n, 0);
  endtask

  task automatic t_loss();
    in_ok = 0; step(); chk("R12 off", mode, 0); chk("R12 stat", stat_n, 1);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got 1 expected 0");
    finish_run();
  end

  initial begin
    @(negedge clk); step();
    t_reset(); t_phase(); t_pre_fault(); t_rset(); t_eoc(); t_ntc(); t_therm(); t_loss();
    finish_run();
  end
endmodule